// File: doc/BRIEF.md
# Warp-Uniform Constant Read Broadcaster

This block serves one 32-lane load from a small read-only constant store. A request is a vector of byte addresses, one per lane, plus an active mask. The block merges active lanes that point at the same 32-bit word and reads each distinct word once. Each word it reads is copied to every lane that asked for it. When the last lane has its word, the block pulses a completion strobe and presents all 32 results together, along with a count of the store reads that the request cost.

The cost of a request therefore follows how far the lanes diverge. A warp-uniform address costs a single read. Fully divergent lanes cost one read per lane, issued back to back.

The lanes can only read the store. A separate host port fills it between requests. The store is an on-chip synchronous RAM with one read port. `ADDR_W` sets the address width: the default of 12 bits gives a 4 KB space, and a value of 16 gives the full 64 KB space.

Top module: `warp_const_bcast`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, `rsp_reads` is 0 and every lane of `rsp_data` is 0.
- R2: If every active lane addresses the same word, the block performs exactly one store read (`rsp_reads` = 1) and delivers that word to all active lanes. `done` is high in the second cycle after the accepting edge.
- R3: If the active lanes address N distinct words, the block performs N reads, one per cycle, and `rsp_reads` = N. Each active lane receives the word at its own address. `done` is high N+1 cycles after the accepting edge.
- R4: The word index of a lane is its address with bits [1:0] dropped. Addresses that differ only in those two bits share one read.
- R5: A lane whose `req_mask` bit is 0 returns zero and never causes a read. An all-zero mask completes with `rsp_reads` = 0, and `done` is high one cycle after the accepting edge.
- R6: Distinct words are read in ascending order of the lowest lane index that requests each word. The k-th distinct word is read at the k-th rising edge after acceptance.
- R7: `req_ready` is low from the accepting edge until `done` is high. A `req_valid` seen while `req_ready` is low is ignored. `req_ready` is 1 in the cycle in which `done` is high.
- R8: `rsp_data` and `rsp_reads` keep their values after `done` until the next request is accepted.
- R9: A host write and a store read of the same word at the same edge return the old word. Any read at a later edge returns the new word.
- R10: `done` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A lane request is present |
| req_ready | output | 1 | Idle; a request is taken at this edge |
| req_mask | input | LANES | Active lanes, bit i for lane i |
| req_addr | input | LANES*ADDR_W | Byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| host_we | input | 1 | Host store write enable |
| host_waddr | input | ADDR_W-2 | Host write word index |
| host_wdata | input | DATA_W | Host write data |
| done | output | 1 | Completion strobe, one cycle |
| rsp_data | output | LANES*DATA_W | Lane results, lane i at bits [i*DATA_W +: DATA_W] |
| rsp_reads | output | $clog2(LANES+1) | Store reads issued for the last request |

## Verification
A host write and a lane read can reach the same store word at the same clock edge. Under R6 the bench knows the edge at which each distinct word is read. It places a host write either on that edge or on an earlier one, inside uniform and two-way divergent requests. It expects the old word for lanes whose word is read at or before the write edge and the new word for lanes whose word is read after it. A wrong read order or a wrong collision rule therefore shows up directly in the lane results.

// File: rtl/warp_const_bcast.sv
module warp_const_bcast #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [LANES-1:0]           req_mask,
  input  logic [LANES*ADDR_W-1:0]    req_addr,
  input  logic                       host_we,
  input  logic [ADDR_W-3:0]          host_waddr,
  input  logic [DATA_W-1:0]          host_wdata,
  output logic                       done,
  output logic [LANES*DATA_W-1:0]    rsp_data,
  output logic [$clog2(LANES+1)-1:0] rsp_reads
);

  localparam int WA_W   = ADDR_W - 2;
  localparam int WORDS  = 1 << WA_W;
  localparam int LIDX_W = $clog2(LANES);
  localparam int CNT_W  = $clog2(LANES+1);

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rd_q;
  logic [WA_W-1:0]   wq  [LANES];
  logic [DATA_W-1:0] res [LANES];

  logic              busy, done_q, hit_v;
  logic [LANES-1:0]  pend, mask_q, hit_q, match;
  logic [CNT_W-1:0]  cnt;
  logic [LIDX_W-1:0] lead;
  logic [WA_W-1:0]   lead_w;

  wire accept = req_valid && !busy;
  wire issue  = busy && (pend != '0);

  assign req_ready = !busy;
  assign done      = done_q;
  assign rsp_reads = cnt;

  always_comb begin
    lead = '0;
    for (int i = LANES-1; i >= 0; i--)
      if (pend[i]) lead = LIDX_W'(i);
  end

  assign lead_w = wq[lead];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign match[g] = pend[g] && (wq[g] == lead_w);
    assign rsp_data[g*DATA_W +: DATA_W] = res[g];

    a_r5_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done && !mask_q[g] |-> res[g] == '0);
  end

  always_ff @(posedge clk) begin
    if (host_we) mem[host_waddr] <= host_wdata;
    if (issue) rd_q <= mem[lead_w];
    if (accept)
      for (int i = 0; i < LANES; i++) wq[i] <= req_addr[i*ADDR_W+2 +: WA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      hit_v  <= 1'b0;
      pend   <= '0;
      mask_q <= '0;
      hit_q  <= '0;
      cnt    <= '0;
      for (int i = 0; i < LANES; i++) res[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        pend   <= req_mask;
        mask_q <= req_mask;
        hit_v  <= 1'b0;
        cnt    <= '0;
        for (int i = 0; i < LANES; i++) res[i] <= '0;
      end else if (busy) begin
        if (hit_v)
          for (int i = 0; i < LANES; i++)
            if (hit_q[i]) res[i] <= rd_q;
        hit_v <= issue;
        hit_q <= match;
        if (issue) begin
          pend <= pend & ~match;
          cnt  <= cnt + 1'b1;
        end else begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && $past(!req_ready));

  a_r3_one_read_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && $past(!req_ready) |->
      (rsp_reads == $past(rsp_reads)) || (rsp_reads == $past(rsp_reads) + 1'b1));

  a_r2_pending_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> $countones(pend) < $countones($past(pend)));

  a_r3_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_reads <= CNT_W'(LANES));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !req_valid |=> $stable(rsp_reads) && $stable(rsp_data));

endmodule

// File: tb/warp_const_bcast_tb_top.sv
module warp_const_bcast_tb_top;
  localparam int LANES = 32, ADDR_W = 12, DATA_W = 32;
  localparam int WA_W = ADDR_W - 2, WORDS = 1 << WA_W, CNT_W = $clog2(LANES+1);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, host_we = 0, done;
  logic [LANES-1:0] req_mask = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic [WA_W-1:0] host_waddr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic [LANES*DATA_W-1:0] rsp_data;
  logic [CNT_W-1:0] rsp_reads;

  int checks = 0, failures = 0;
  logic [DATA_W-1:0] mdl [WORDS];
  logic [ADDR_W-1:0] t_addr [LANES];
  logic [LANES-1:0] t_mask;

  always #5 clk = ~clk;

  warp_const_bcast #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_addr(req_addr), .host_we(host_we),
    .host_waddr(host_waddr), .host_wdata(host_wdata), .done(done),
    .rsp_data(rsp_data), .rsp_reads(rsp_reads));

  function automatic logic [DATA_W-1:0] pat(int i);
    return (i * 32'h9E3779B1) ^ 32'h0000C0DE;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic host_write(logic [WA_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    host_we = 1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
    mdl[a] = d;
  endtask

  task automatic run_req(string tag, int hw_at, logic [WA_W-1:0] hwa,
                         logic [DATA_W-1:0] hwd, bit intrude);
    logic [DATA_W-1:0] exp_d [LANES];
    int pos [LANES];
    int n = 0, lat = -1, bad = 0, first_bad = -1;
    logic [CNT_W-1:0] rd_hold;
    logic [LANES*DATA_W-1:0] data_hold;
    for (int i = 0; i < LANES; i++) begin
      pos[i] = 0;
      if (t_mask[i]) begin
        for (int j = 0; j < i; j++)
          if (pos[i] == 0 && t_mask[j] && t_addr[j][ADDR_W-1:2] == t_addr[i][ADDR_W-1:2])
            pos[i] = pos[j];
        if (pos[i] == 0) begin n++; pos[i] = n; end
      end
    end
    for (int i = 0; i < LANES; i++) begin
      if (!t_mask[i]) exp_d[i] = '0;
      else if (hw_at > 0 && t_addr[i][ADDR_W-1:2] == hwa && pos[i] > hw_at) exp_d[i] = hwd;
      else exp_d[i] = mdl[t_addr[i][ADDR_W-1:2]];
    end
    @(negedge clk);
    chk(req_ready == 1, {tag, " R7 ready before request"}, req_ready, 1);
    req_valid = 1; req_mask = t_mask;
    for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = t_addr[i];
    @(posedge clk);
    for (int k = 1; k < 100; k++) begin
      @(negedge clk);
      if (done) begin lat = k - 1; break; end
      req_valid = intrude && k <= 2;
      if (intrude && k <= 2) begin
        req_mask = ~t_mask;
        req_addr = ~req_addr;
        chk(req_ready == 0, {tag, " R7 ready low while busy"}, req_ready, 0);
      end
      host_we = (k == hw_at); host_waddr = hwa; host_wdata = hwd;
    end
    req_valid = 0; host_we = 0;
    if (hw_at > 0) mdl[hwa] = hwd;
    chk(lat == n + 1, {tag, " R2 R3 completion latency"}, lat, n + 1);
    chk(rsp_reads == CNT_W'(n), {tag, " R3 read count"}, rsp_reads, n);
    chk(req_ready == 1, {tag, " R7 ready at done"}, req_ready, 1);
    for (int i = 0; i < LANES; i++)
      if (rsp_data[i*DATA_W +: DATA_W] !== exp_d[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    if (first_bad >= 0)
      $display("FAIL %s lane %0d data actual=%0h expected=%0h", tag, first_bad,
               rsp_data[first_bad*DATA_W +: DATA_W], exp_d[first_bad]);
    chk(bad == 0, {tag, " R2 R3 R4 R5 lane data mismatches"}, bad, 0);
    rd_hold = rsp_reads; data_hold = rsp_data;
    @(negedge clk);
    chk(done == 0, {tag, " R10 done single pulse"}, done, 0);
    chk(rsp_reads == rd_hold && rsp_data == data_hold, {tag, " R8 results held"},
        rsp_reads, rd_hold);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int ps;
    logic [WA_W-1:0] pool [LANES];
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R1 reset ready", req_ready, 1);
    chk(done == 0, "R1 reset done", done, 0);
    chk(rsp_reads == 0, "R1 reset reads", rsp_reads, 0);
    chk(rsp_data == '0, "R1 reset data", 0, 0);
    rst_n = 1;
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      host_we = 1; host_waddr = WA_W'(w); host_wdata = pat(w); mdl[w] = pat(w);
    end
    @(negedge clk); host_we = 0;

    t_mask = '1;
    for (int i = 0; i < LANES; i++) t_addr[i] = {WA_W'(37), 2'(i)};
    run_req("uniform R2 R4", 0, '0, '0, 0);

    for (int i = 0; i < LANES; i++) t_addr[i] = {WA_W'(100 + 3*i), 2'b00};
    run_req("divergent32 R3", 0, '0, '0, 0);

    t_mask = '0;
    run_req("empty mask R5", 0, '0, '0, 0);

    t_mask = 32'h5555_5555;
    for (int i = 0; i < LANES; i++) t_addr[i] = {WA_W'(200 + i), 2'b10};
    run_req("sparse R5", 0, '0, '0, 0);

    t_mask = '1;
    for (int i = 0; i < LANES; i++) t_addr[i] = {WA_W'(300 + (i % 4)), 2'b01};
    run_req("busy intrude R7", 0, '0, '0, 1);

    for (int i = 0; i < LANES; i++) t_addr[i] = {WA_W'(55), 2'b00};
    run_req("collide same edge R9", 1, WA_W'(55), 32'hA5A5_0001, 0);
    run_req("after collide R9", 0, '0, '0, 0);

    for (int i = 0; i < LANES; i++) t_addr[i] = {(i < 16) ? WA_W'(70) : WA_W'(71), 2'b00};
    run_req("order write B early R6", 1, WA_W'(71), 32'hB0B0_0002, 0);
    run_req("order write A late R6", 2, WA_W'(70), 32'hA0A0_0003, 0);

    for (int r = 0; r < 300; r++) begin
      case ($urandom % 5)
        0: ps = 1; 1: ps = 2; 2: ps = 3; 3: ps = 8; default: ps = 32;
      endcase
      for (int p = 0; p < ps; p++) pool[p] = WA_W'($urandom);
      for (int i = 0; i < LANES; i++) t_addr[i] = {pool[$urandom % ps], 2'($urandom)};
      t_mask = ($urandom % 3 == 0) ? '1 : LANES'($urandom);
      run_req("random R3", 0, '0, '0, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule